// File: doc/BRIEF.md
# Multi-NCO Phase Modulation Engine

This block rotates a stream of complex I/Q samples by a phase taken from one of several numerically controlled oscillators. Every oscillator holds four words: a running phase accumulator, a per-sample increment, a fixed offset and an accumulated frame. All accumulators advance on every clock, whether or not their oscillator is the one in use. A single command stream picks which oscillator drives the output for a stretch of samples. The stream also edits the oscillator words, and it can stall on an external trigger or on a barrier signal from the sequencer.

Edits to oscillator words (clear, offset, increment, frame add) do not act when they are accepted. They are held in a small ordered queue and applied all at once at the next instruction boundary. A boundary is the last sample of a playing modulate command, or the release of a trigger or barrier stall. This lets a frame change (a virtual Z rotation) land exactly between two pulses, with no idle sample. The applied phase is also reported on its own port, so a downstream stage can use it directly.

Top module: `mne_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_phase`, `busy`, `out_i` and `out_q` are zero. All oscillator words clear to zero.
- R2: A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. The `cmd_op` codes are 0 trigger-wait, 1 barrier-wait, 2 clear, 3 set offset, 4 set increment, 5 frame add, 6 modulate, 7 no-op. Code 7 is always accepted and changes nothing. For modulate, `cmd_arg[15:0]` is the sample count and `cmd_arg[17:16]` is the oscillator index.
- R3: When no modulate is playing, `out_i`/`out_q` equal the `in_i`/`in_q` of the previous cycle, and `out_phase` is zero.
- R4: A modulate with count N (zero counts as one) holds `busy` high for exactly N cycles, starting the cycle after acceptance. In each of those cycles the registered outputs of the next cycle carry phase = accumulator + offset + frame of the selected oscillator, taken modulo 2^24.
- R5: Each cycle every oscillator's accumulator adds that oscillator's current increment. A new increment is first added on the cycle after it is applied.
- R6: Codes 2–5 are held and applied only at the next boundary. They are applied in arrival order to every oscillator whose bit is set in `cmd_mask`. Set offset and set increment load `cmd_arg`; frame add adds `cmd_arg` to the frame.
- R7: The last sample of a modulate is a boundary. A trigger-wait, barrier-wait or modulate command is accepted only when idle or on that last sample, so consecutive modulates play with no gap.
- R8: A trigger-wait stalls until `trig_in` is high, and a barrier-wait stalls until `sync_in` is high. That release cycle is a boundary. The other of the two signals has no effect during the stall, and `busy` stays low.
- R9: Clear sets the accumulator and frame of each targeted oscillator to zero and leaves its offset and increment unchanged.
- R10: During a modulate, the output is the input rotated counter-clockwise by the angle given by the top 6 phase bits (64 steps per turn). The sine and cosine are scaled by 32767/32768, and the result saturates to the signed 16-bit range.
- R11: At most four edits can be held. While four are held, `cmd_ready` is low for codes 2–5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command code |
| cmd_mask | input | 4 | Oscillator target mask for edits |
| cmd_arg | input | 24 | Edit value, or modulate count and index |
| trig_in | input | 1 | Trigger that releases a trigger-wait |
| sync_in | input | 1 | Barrier release from the sequencer |
| in_i | input | 16 | Input sample, in-phase, signed |
| in_q | input | 16 | Input sample, quadrature, signed |
| out_i | output | 16 | Output sample, in-phase, signed |
| out_q | output | 16 | Output sample, quadrature, signed |
| out_phase | output | 24 | Phase applied to the current output sample |
| busy | output | 1 | A modulate is playing |

## Verification
An accumulator that misses one step, or a held edit applied one cycle early or late, shows as a wrong `out_phase` on the very next modulated sample. Because the oscillators keep running, the error is still visible on every later sample of that oscillator. An edit applied in the wrong order shows as a nonzero frame after a clear, or a lost frame, on the first sample after the boundary. A control state that ends early or late shows at once as `busy` and the pass-through path being one cycle off against the command count.

// File: rtl/mne_pkg.sv
package mne_pkg;

    localparam int NCO_N = 4;
    localparam int PH_W  = 24;
    localparam int SMP_W = 16;
    localparam int CNT_W = 16;
    localparam int SEL_W = $clog2(NCO_N);
    localparam int LUT_W = 6;
    localparam int QTR   = 1 << (LUT_W - 2);

    typedef enum logic [2:0] {
        OP_WAIT   = 3'd0,
        OP_SYNC   = 3'd1,
        OP_CLEAR  = 3'd2,
        OP_OFFSET = 3'd3,
        OP_INCR   = 3'd4,
        OP_FRAME  = 3'd5,
        OP_MOD    = 3'd6,
        OP_NOP    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_PLAY, ST_TRIG, ST_SYNC
    } st_e;

    typedef struct packed {
        op_e               op;
        logic [NCO_N-1:0]  mask;
        logic [PH_W-1:0]   arg;
    } held_t;

    function automatic logic is_edit(op_e op);
        return (op == OP_CLEAR) || (op == OP_OFFSET) ||
               (op == OP_INCR)  || (op == OP_FRAME);
    endfunction

    // one quarter of a sine period, 16 steps, scaled to 32767
    function automatic logic signed [SMP_W-1:0] quarter_sine(logic [4:0] k);
        case (k)
            5'd0:  return 16'sd0;
            5'd1:  return 16'sd3212;
            5'd2:  return 16'sd6393;
            5'd3:  return 16'sd9512;
            5'd4:  return 16'sd12539;
            5'd5:  return 16'sd15446;
            5'd6:  return 16'sd18204;
            5'd7:  return 16'sd20787;
            5'd8:  return 16'sd23170;
            5'd9:  return 16'sd25329;
            5'd10: return 16'sd27245;
            5'd11: return 16'sd28898;
            5'd12: return 16'sd30273;
            5'd13: return 16'sd31356;
            5'd14: return 16'sd32137;
            5'd15: return 16'sd32609;
            5'd16: return 16'sd32767;
            default: return 16'sd0;
        endcase
    endfunction

    function automatic logic signed [SMP_W-1:0] lut_sin(logic [LUT_W-1:0] idx);
        logic [4:0] k;
        logic signed [SMP_W-1:0] mag;
        k   = {1'b0, idx[LUT_W-3:0]};
        mag = idx[LUT_W-2] ? quarter_sine(5'd16 - k) : quarter_sine(k);
        return idx[LUT_W-1] ? -mag : mag;
    endfunction

endpackage

// File: rtl/mne_hold_queue.sv
module mne_hold_queue
    import mne_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    push,
    input  held_t                   push_ent,
    input  logic                    flush,
    output held_t [DEPTH-1:0]       ent,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                    full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    assign full = (count == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ent   <= '0;
        end else if (flush) begin
            count <= push ? CW'(1) : '0;
            if (push) ent[0] <= push_ent;
        end else if (push) begin
            ent[count[IW-1:0]] <= push_ent;
            count <= count + CW'(1);
        end
    end

    a_r11_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        !(push && full));

    a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
        (flush && !push) |=> (count == '0));

endmodule

// File: rtl/mne_nco_bank.sv
module mne_nco_bank
    import mne_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       apply,
    input  held_t [DEPTH-1:0]          ent,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [SEL_W-1:0]           sel,
    output logic [PH_W-1:0]            phase
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [PH_W-1:0] acc [NCO_N];
    logic [PH_W-1:0] inc [NCO_N];
    logic [PH_W-1:0] off [NCO_N];
    logic [PH_W-1:0] frm [NCO_N];
    logic [PH_W-1:0] n_acc [NCO_N];
    logic [PH_W-1:0] n_inc [NCO_N];
    logic [PH_W-1:0] n_off [NCO_N];
    logic [PH_W-1:0] n_frm [NCO_N];

    always_comb begin
        for (int k = 0; k < NCO_N; k++) begin
            n_acc[k] = acc[k] + inc[k];
            n_inc[k] = inc[k];
            n_off[k] = off[k];
            n_frm[k] = frm[k];
        end
        if (apply) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (CW'(j) < count) begin
                    for (int k = 0; k < NCO_N; k++) begin
                        if (ent[j].mask[k]) begin
                            case (ent[j].op)
                                OP_CLEAR:  begin n_acc[k] = '0; n_frm[k] = '0; end
                                OP_OFFSET: n_off[k] = ent[j].arg;
                                OP_INCR:   n_inc[k] = ent[j].arg;
                                OP_FRAME:  n_frm[k] = n_frm[k] + ent[j].arg;
                                default:   ;
                            endcase
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NCO_N; k++) begin
            if (rst) begin
                acc[k] <= '0; inc[k] <= '0; off[k] <= '0; frm[k] <= '0;
            end else begin
                acc[k] <= n_acc[k]; inc[k] <= n_inc[k];
                off[k] <= n_off[k]; frm[k] <= n_frm[k];
            end
        end
    end

    assign phase = acc[sel] + off[sel] + frm[sel];

    for (genvar g = 0; g < NCO_N; g++) begin : g_chk
        a_r5_free_running: assert property (@(posedge clk) disable iff (rst)
            !apply |=> (acc[g] == $past(acc[g]) + $past(inc[g])));
    end

endmodule

// File: rtl/mne_rotator.sv
module mne_rotator
    import mne_pkg::*;
(
    input  logic [LUT_W-1:0]        idx,
    input  logic signed [SMP_W-1:0] in_i,
    input  logic signed [SMP_W-1:0] in_q,
    output logic signed [SMP_W-1:0] rot_i,
    output logic signed [SMP_W-1:0] rot_q
);
    localparam int PW = 2 * SMP_W;
    localparam int SW = PW + 1;

    logic signed [SMP_W-1:0] s, c;
    logic signed [PW-1:0]    p_ic, p_qs, p_is, p_qc;
    logic signed [SW-1:0]    x_i, x_q, sh_i, sh_q;

    function automatic logic signed [SMP_W-1:0] clamp(logic signed [SW-1:0] v);
        logic [SW-SMP_W:0] top;
        top = v[SW-1:SMP_W-1];
        if (top == '0 || top == '1) return v[SMP_W-1:0];
        return v[SW-1] ? {1'b1, {(SMP_W-1){1'b0}}} : {1'b0, {(SMP_W-1){1'b1}}};
    endfunction

    always_comb begin
        s    = lut_sin(idx);
        c    = lut_sin(idx + LUT_W'(QTR));
        p_ic = in_i * c;
        p_qs = in_q * s;
        p_is = in_i * s;
        p_qc = in_q * c;
        x_i  = {p_ic[PW-1], p_ic} - {p_qs[PW-1], p_qs};
        x_q  = {p_is[PW-1], p_is} + {p_qc[PW-1], p_qc};
        sh_i = x_i >>> (SMP_W - 1);
        sh_q = x_q >>> (SMP_W - 1);
        rot_i = clamp(sh_i);
        rot_q = clamp(sh_q);
    end

endmodule

// File: rtl/mne_top.sv
module mne_top
    import mne_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [2:0]              cmd_op,
    input  logic [NCO_N-1:0]        cmd_mask,
    input  logic [PH_W-1:0]         cmd_arg,
    input  logic                    trig_in,
    input  logic                    sync_in,
    input  logic signed [SMP_W-1:0] in_i,
    input  logic signed [SMP_W-1:0] in_q,
    output logic signed [SMP_W-1:0] out_i,
    output logic signed [SMP_W-1:0] out_q,
    output logic [PH_W-1:0]         out_phase,
    output logic                    busy
);
    localparam int CW = $clog2(QDEPTH + 1);

    st_e                 st;
    logic [CNT_W-1:0]    left;
    logic [SEL_W-1:0]    sel;
    op_e                 op;
    logic                last_smp, flow_slot, fire, boundary, edit_push;
    held_t [QDEPTH-1:0]  q_ent;
    logic [CW-1:0]       q_cnt;
    logic                q_full;
    logic [PH_W-1:0]     phase;
    logic signed [SMP_W-1:0] rot_i, rot_q;

    assign op        = op_e'(cmd_op);
    assign last_smp  = (st == ST_PLAY) && (left == CNT_W'(1));
    assign flow_slot = (st == ST_IDLE) || last_smp;
    assign cmd_ready = is_edit(op) ? !q_full : ((op == OP_NOP) || flow_slot);
    assign fire      = cmd_valid && cmd_ready;
    assign edit_push = fire && is_edit(op);
    assign boundary  = last_smp || ((st == ST_TRIG) && trig_in) ||
                       ((st == ST_SYNC) && sync_in);
    assign busy      = (st == ST_PLAY);

    mne_hold_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst(rst), .push(edit_push),
        .push_ent('{op: op, mask: cmd_mask, arg: cmd_arg}),
        .flush(boundary), .ent(q_ent), .count(q_cnt), .full(q_full)
    );

    mne_nco_bank #(.DEPTH(QDEPTH)) u_bank (
        .clk(clk), .rst(rst), .apply(boundary), .ent(q_ent),
        .count(q_cnt), .sel(sel), .phase(phase)
    );

    mne_rotator u_rot (
        .idx(phase[PH_W-1 -: LUT_W]), .in_i(in_i), .in_q(in_q),
        .rot_i(rot_i), .rot_q(rot_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            left <= '0;
            sel  <= '0;
        end else begin
            if (st == ST_PLAY) begin
                left <= left - CNT_W'(1);
                if (last_smp) st <= ST_IDLE;
            end
            if ((st == ST_TRIG && trig_in) || (st == ST_SYNC && sync_in))
                st <= ST_IDLE;
            if (fire) begin
                case (op)
                    OP_MOD: begin
                        st   <= ST_PLAY;
                        left <= (cmd_arg[CNT_W-1:0] == '0) ? CNT_W'(1)
                                                          : cmd_arg[CNT_W-1:0];
                        sel  <= cmd_arg[CNT_W +: SEL_W];
                    end
                    OP_WAIT: st <= ST_TRIG;
                    OP_SYNC: st <= ST_SYNC;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_phase <= '0;
            out_i     <= '0;
            out_q     <= '0;
        end else if (st == ST_PLAY) begin
            out_phase <= phase;
            out_i     <= rot_i;
            out_q     <= rot_q;
        end else begin
            out_phase <= '0;
            out_i     <= in_i;
            out_q     <= in_q;
        end
    end

    a_r3_idle_zero_phase: assert property (@(posedge clk) disable iff (rst)
        (st != ST_PLAY) |=> (out_phase == '0));

    a_r3_idle_passthrough: assert property (@(posedge clk) disable iff (rst)
        (st != ST_PLAY) |=> (out_i == $past(in_i) && out_q == $past(in_q)));

    a_r7_play_ends: assert property (@(posedge clk) disable iff (rst)
        (last_smp && !fire) |=> (st == ST_IDLE));

    a_r8_trigger_stall: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TRIG && !trig_in) |=> (st == ST_TRIG));

    a_r8_barrier_stall: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SYNC && !sync_in) |=> (st == ST_SYNC));

endmodule

// File: tb/sim_mne_top.sv
`timescale 1ns/1ps
module sim_mne_top;

    logic clk = 0;
    logic rst = 1;
    logic cmd_valid = 0;
    logic cmd_ready;
    logic [2:0] cmd_op = 3'd7;
    logic [3:0] cmd_mask = '0;
    logic [23:0] cmd_arg = '0;
    logic trig_in = 0, sync_in = 0;
    logic signed [15:0] in_i = 0, in_q = 0;
    logic signed [15:0] out_i, out_q;
    logic [23:0] out_phase;
    logic busy;

    always #2.5 clk = ~clk;

    mne_top u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_mask(cmd_mask), .cmd_arg(cmd_arg),
        .trig_in(trig_in), .sync_in(sync_in), .in_i(in_i), .in_q(in_q),
        .out_i(out_i), .out_q(out_q), .out_phase(out_phase), .busy(busy)
    );

    int checks = 0, failures = 0;
    string cur_req = "R1";
    bit chk_on = 0, rnd_mode = 0, done = 0;

    // reference model
    logic [23:0] m_acc [4], m_inc [4], m_off [4], m_frm [4];
    logic [2:0]  q_op [4];
    logic [3:0]  q_mask [4];
    logic [23:0] q_arg [4];
    int m_qn = 0, m_st = 0, m_left = 0, m_sel = 0;
    bit m_fired = 0;
    logic [23:0] e_phase = 0;
    bit e_busy = 0, e_pass = 1;
    int e_i = 0, e_q = 0;
    real e_ri = 0.0, e_rq = 0.0;

    function automatic bit is_ed(logic [2:0] op);
        return op inside {3'd2, 3'd3, 3'd4, 3'd5};
    endfunction

    function automatic bit m_ready(logic [2:0] op);
        if (is_ed(op)) return m_qn < 4;
        if (op == 3'd7) return 1;
        return (m_st == 0) || (m_st == 1 && m_left == 1);
    endfunction

    function automatic real clampr(real v);
        if (v > 32767.0) return 32767.0;
        if (v < -32768.0) return -32768.0;
        return v;
    endfunction

    always @(posedge clk) begin
        m_fired = 0;
        if (rst) begin
            for (int k = 0; k < 4; k++) begin
                m_acc[k] = 0; m_inc[k] = 0; m_off[k] = 0; m_frm[k] = 0;
            end
            m_qn = 0; m_st = 0; m_left = 0; m_sel = 0;
            e_phase = 0; e_busy = 0; e_pass = 1; e_i = 0; e_q = 0;
        end else begin
            bit fire, bnd;
            real ang;
            fire = cmd_valid && m_ready(cmd_op);
            m_fired = fire;
            bnd = (m_st == 1 && m_left == 1) || (m_st == 2 && trig_in) ||
                  (m_st == 3 && sync_in);
            if (m_st == 1) begin
                e_phase = m_acc[m_sel] + m_off[m_sel] + m_frm[m_sel];
                ang = 2.0 * 3.14159265358979 * real'(e_phase[23:18]) / 64.0;
                e_ri = clampr((real'(in_i) * $cos(ang) - real'(in_q) * $sin(ang)) * 32767.0 / 32768.0);
                e_rq = clampr((real'(in_i) * $sin(ang) + real'(in_q) * $cos(ang)) * 32767.0 / 32768.0);
                e_pass = 0;
            end else begin
                e_phase = 0; e_pass = 1; e_i = in_i; e_q = in_q;
            end
            for (int k = 0; k < 4; k++) m_acc[k] = m_acc[k] + m_inc[k];
            if (bnd) begin
                for (int j = 0; j < m_qn; j++)
                    for (int k = 0; k < 4; k++)
                        if (q_mask[j][k]) case (q_op[j])
                            3'd2: begin m_acc[k] = 0; m_frm[k] = 0; end
                            3'd3: m_off[k] = q_arg[j];
                            3'd4: m_inc[k] = q_arg[j];
                            3'd5: m_frm[k] = m_frm[k] + q_arg[j];
                            default: ;
                        endcase
                m_qn = 0;
            end
            if (fire && is_ed(cmd_op)) begin
                q_op[m_qn] = cmd_op; q_mask[m_qn] = cmd_mask; q_arg[m_qn] = cmd_arg;
                m_qn++;
            end
            if (m_st == 1) begin
                m_left--;
                if (m_left == 0) m_st = 0;
            end
            if ((m_st == 2 && trig_in) || (m_st == 3 && sync_in)) m_st = 0;
            if (fire) case (cmd_op)
                3'd6: begin
                    m_st = 1;
                    m_left = (cmd_arg[15:0] == 0) ? 1 : int'(cmd_arg[15:0]);
                    m_sel = int'(cmd_arg[17:16]);
                end
                3'd0: m_st = 2;
                3'd1: m_st = 3;
                default: ;
            endcase
            e_busy = (m_st == 1);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit near(int a, real e);
        real d;
        d = real'(a) - e;
        return (d < 3.0) && (d > -3.0);
    endfunction

    always @(negedge clk) begin
        in_i = 16'($urandom);
        in_q = 16'($urandom);
        if (rnd_mode) begin
            trig_in = ($urandom % 5) == 0;
            sync_in = ($urandom % 5) == 0;
        end
    end

    always @(negedge clk) begin
        #1;
        if (!rst && chk_on) begin
            chk(out_phase == e_phase, cur_req, "out_phase", out_phase, e_phase);
            chk(busy == e_busy, "R4", "busy", busy, e_busy);
            if (e_pass) begin
                chk(out_i == e_i && out_q == e_q, "R3", "passthrough_i",
                    out_i, e_i);
            end else begin
                chk(near(out_i, e_ri), "R10", "rot_i", out_i, longint'(e_ri));
                chk(near(out_q, e_rq), "R10", "rot_q", out_q, longint'(e_rq));
            end
            chk(cmd_ready == m_ready(cmd_op), cur_req, "cmd_ready",
                cmd_ready, m_ready(cmd_op));
        end
    end

    task automatic send(input logic [2:0] op, input logic [3:0] mask,
                        input logic [23:0] arg, input int tmo);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_mask = mask; cmd_arg = arg;
        for (int t = 0; t < tmo; t++) begin
            @(posedge clk); #0.5;
            if (m_fired) begin
                cmd_valid = 0; cmd_op = 3'd7;
                return;
            end
        end
        cmd_valid = 0; cmd_op = 3'd7;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit which);
        @(negedge clk);
        if (which) sync_in = 1; else trig_in = 1;
        @(negedge clk);
        trig_in = 0; sync_in = 0;
    endtask

    function automatic logic [23:0] modarg(input int sel, input int n);
        return {6'd0, 2'(sel), 16'(n)};
    endfunction

    initial begin
        void'($urandom(32'd20240601));
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(out_phase == 0 && busy == 0, "R1", "reset phase/busy", out_phase, 0);
        chk(out_i == 0 && out_q == 0, "R1", "reset samples", out_i, 0);
        @(negedge clk); rst = 0;
        #1;
        chk(out_phase == 0 && busy == 0, "R1", "first cycle after reset", out_phase, 0);
        chk_on = 1;

        cur_req = "R3"; idle(6);

        // R6: edits held while idle, take effect at end of first modulate
        cur_req = "R6";
        send(3'd4, 4'b0001, 24'h040000, 20);
        send(3'd4, 4'b0010, 24'h0C0000, 20);
        send(3'd3, 4'b0001, 24'h400000, 20);
        send(3'd5, 4'b0100, 24'h200000, 20);
        send(3'd6, 4'd0, modarg(0, 4), 20);
        idle(6);

        // R7: back-to-back modulates, zero count plays one sample
        cur_req = "R7";
        send(3'd6, 4'd0, modarg(0, 6), 20);
        send(3'd6, 4'd0, modarg(1, 5), 20);
        send(3'd6, 4'd0, modarg(2, 0), 20);
        idle(4);

        // R5: unselected oscillators keep advancing
        cur_req = "R5";
        send(3'd6, 4'd0, modarg(0, 3), 20);
        idle(7);
        send(3'd6, 4'd0, modarg(1, 3), 20);
        idle(5);

        // R8: trigger and barrier stalls, the other signal ignored
        cur_req = "R8";
        send(3'd0, 4'd0, 24'd0, 20);
        send(3'd5, 4'b0001, 24'h010000, 20);
        pulse(1);
        idle(4);
        pulse(0);
        send(3'd6, 4'd0, modarg(0, 3), 20);
        send(3'd1, 4'd0, 24'd0, 20);
        pulse(0);
        idle(3);
        pulse(1);
        send(3'd6, 4'd0, modarg(0, 2), 20);
        idle(4);

        // R9: clear resets accumulator and frame only
        cur_req = "R9";
        send(3'd6, 4'd0, modarg(0, 10), 20);
        send(3'd2, 4'b0011, 24'd0, 20);
        send(3'd6, 4'd0, modarg(0, 4), 20);
        send(3'd6, 4'd0, modarg(1, 4), 20);
        idle(4);

        // R6: arrival order (frame then clear, clear then frame)
        cur_req = "R6";
        send(3'd6, 4'd0, modarg(0, 8), 20);
        send(3'd5, 4'b0001, 24'h100000, 20);
        send(3'd2, 4'b0001, 24'd0, 20);
        send(3'd6, 4'd0, modarg(0, 8), 20);
        send(3'd2, 4'b0001, 24'd0, 20);
        send(3'd5, 4'b0001, 24'h080000, 20);
        send(3'd6, 4'd0, modarg(0, 3), 20);
        idle(5);

        // R11: four held edits fill the queue
        cur_req = "R11";
        send(3'd0, 4'd0, 24'd0, 20);
        for (int n = 0; n < 4; n++) send(3'd4, 4'(1 << n), 24'(32'h011000 * (n + 1)), 20);
        send(3'd3, 4'b1111, 24'h123456, 3);
        @(negedge clk); cmd_valid = 1; cmd_op = 3'd3; #1;
        chk(cmd_ready == 0, "R11", "ready with full queue", cmd_ready, 0);
        @(negedge clk); cmd_valid = 0; cmd_op = 3'd7;
        pulse(0);
        send(3'd6, 4'd0, modarg(3, 6), 20);
        idle(8);

        // R2 / R10: random command mix
        cur_req = "R2";
        rnd_mode = 1;
        for (int n = 0; n < 1500; n++) begin
            int r;
            r = $urandom % 10;
            if (r < 4) send(3'd6, 4'd0, modarg($urandom % 4, $urandom % 13), 40);
            else if (r < 8) send(3'(2 + $urandom % 4), 4'($urandom), 24'($urandom), 40);
            else if (r == 8) send(3'($urandom % 2), 4'd0, 24'd0, 40);
            else send(3'd7, 4'($urandom), 24'($urandom), 40);
        end
        rnd_mode = 0; trig_in = 0; sync_in = 0;
        idle(20);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL R7 watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule